// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets synchronous on-chip logic read and write an external 128K x 8 asynchronous static RAM. The user side offers a single-request interface: a request strobe with a write flag, a 17-bit byte address and an 8-bit write byte. The controller returns the read byte and a one-cycle completion pulse.

On the memory side it drives a low-true and a high-true chip select, a low-true write strobe, a low-true output enable, the address lines, and an 8-bit data bus. The data bus is split at the pad boundary into an outgoing byte, a drive enable, and an incoming byte. Every phase length is counted in clock cycles. The counts are derived at elaboration from nanosecond minimums and the clock period, each rounded up.

A write selects the chip and then lowers the write strobe. It turns its own drivers on only after that, holds the byte through the rising write strobe, and then releases everything. A read selects the chip with output enable low for an access count and captures the bus on the final edge. Requests are taken only while idle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and whenever idle, the pins are: low-true select high, high-true select low, write strobe high, output enable high, data drive enable low. The completion pulse is low.
- R2: A write accepted with address A and byte D causes exactly one write overlap at the memory. The overlap is low-true select low, high-true select high and write strobe low. At its end, D is stored at A.
- R3: The outgoing byte is driven for at least DATA_CYC cycles before the write strobe rises. It is still driven with the same value in the cycle after the rise.
- R4: The write strobe stays low for DATA_CYC+1 cycles, which is at least the pulse-width count. Output enable stays high for the whole write. Output enable and the write strobe are never low together.
- R5: A read holds both selects active, output enable low and the write strobe high for ACC_CYC cycles. The byte present on the bus in the last of those cycles appears on rsp_rdata.
- R6: The drive enable is never high while output enable is low or while the chip is deselected. It is never high in the first cycle of a low write strobe. It is never high in the cycle right after a cycle with output enable low.
- R7: mem_addr does not change while the chip stays selected.
- R8: rsp_done is high for exactly one cycle per request. Counted in clock edges after the accepting edge, it rises on edge 4+DATA_CYC for a write and on edge ACC_CYC+1 for a read. At the defaults of a 10 ns clock with 12 ns access, 10 ns pulse and 7 ns setup minima, ACC_CYC=2 and DATA_CYC=1. rsp_done is therefore first seen 5 cycles after acceptance for a write and 3 cycles after for a read.
- R9: A request held or changed while a transaction is in progress is neither performed nor queued. It does not alter the address or byte of the transaction in progress.
- R10: rsp_rdata keeps its value until the next read completes, across any number of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_sel_n | output | 1 | Low-true chip select |
| mem_sel | output | 1 | High-true chip select |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_addr | output | 17 | Memory address lines |
| mem_dq_o | output | 8 | Outgoing data byte |
| mem_dq_oe | output | 1 | Data pad drive enable |
| mem_dq_i | input | 8 | Incoming data byte |

## Verification
A wrong phase state or counter shows up within one cycle as a forbidden pin combination: drive enable with output enable low, a drive in the first low write-strobe cycle, or output enable and write strobe low together. It also shows up as a completion pulse off the expected cycle count. A wrong capture edge shows up as the scrambled pre-access byte on rsp_rdata in the same transaction. A latch of the address or byte while busy shows up as a stray write, or as an address change during selection, in the next cycles. The memory model commits data from the pin overlap alone and returns scrambled data before the access count is reached, so these faults become visible on read-back.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSET  = 3'd1,
    PH_WLEAD = 3'd2,
    PH_WDATA = 3'd3,
    PH_WHOLD = 3'd4,
    PH_RACC  = 3'd5
  } phase_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic drv;
  } pin_ctl_t;

  localparam pin_ctl_t PIN_IDLE = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int ceil_cycles(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Memory-side pin pattern for each phase.
  function automatic pin_ctl_t pins_for(input phase_e p);
    pin_ctl_t c;
    c = PIN_IDLE;
    case (p)
      PH_WSET:  begin c.sel_n = 1'b0; c.sel = 1'b1; end
      PH_WLEAD: begin c.sel_n = 1'b0; c.sel = 1'b1; c.we_n = 1'b0; end
      PH_WDATA: begin c.sel_n = 1'b0; c.sel = 1'b1; c.we_n = 1'b0; c.drv = 1'b1; end
      PH_WHOLD: begin c.sel_n = 1'b0; c.sel = 1'b1; c.drv = 1'b1; end
      PH_RACC:  begin c.sel_n = 1'b0; c.sel = 1'b1; c.oe_n = 1'b0; end
      default:  c = PIN_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sramc_seq.sv
`timescale 1ns/1ps
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int ACC_CYC  = 2,
  parameter int DATA_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_e phase_d,
  output logic   accept,
  output logic   capture,
  output logic   finish
);

  localparam int CNT_MAX = max2(ACC_CYC, DATA_CYC) - 1;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    accept  = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            phase_d = PH_WSET;
          end else begin
            phase_d = PH_RACC;
            cnt_d   = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      PH_WSET:  phase_d = PH_WLEAD;
      PH_WLEAD: begin
        phase_d = PH_WDATA;
        cnt_d   = CNT_W'(DATA_CYC - 1);
      end
      PH_WDATA: begin
        if (cnt_q == '0) phase_d = PH_WHOLD;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      PH_WHOLD: begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      PH_RACC: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          capture = 1'b1;
          finish  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: the phase counter never exceeds the longest counted phase
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= CNT_MAX);

  // R9: a new request is taken only after the previous one finished
  a_r9_accept_after_finish: assert property (@(posedge clk) disable iff (rst)
    accept |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/sramc_pins.sv
`timescale 1ns/1ps
module sramc_pins
  import sramc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d,
  output logic   sel_n,
  output logic   sel,
  output logic   we_n,
  output logic   oe_n,
  output logic   drv
);

  pin_ctl_t ctl_q;

  // Registered pin decode of the next phase: glitch-free pins aligned with the phase.
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= PIN_IDLE;
    else     ctl_q <= pins_for(phase_d);
  end

  assign sel_n = ctl_q.sel_n;
  assign sel   = ctl_q.sel;
  assign we_n  = ctl_q.we_n;
  assign oe_n  = ctl_q.oe_n;
  assign drv   = ctl_q.drv;

  // R6: no drive while the memory may drive or is deselected
  a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
    drv |-> (oe_n && !sel_n && sel));

  // R6: drivers stay off in the first cycle of a low write strobe
  a_r6_late_drive: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> !drv);

  // R4: output enable and write strobe never low together
  a_r4_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  // R3: data driven before and after the write-ending edge
  a_r3_setup_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> ($past(drv) && drv));

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic              finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_i;
      done_q <= finish;
    end
  end

  // R10: read data only moves on a capture
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rdata_q));

  // R9: request fields only latched on acceptance
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int T_CLK_NS  = 10,
  parameter int T_ACC_NS  = 12,
  parameter int T_PWE_NS  = 10,
  parameter int T_SD_NS   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int ACC_CYC  = max2(1, ceil_cycles(T_ACC_NS, T_CLK_NS));
  localparam int SD_CYC   = ceil_cycles(T_SD_NS, T_CLK_NS);
  localparam int PWE_CYC  = ceil_cycles(T_PWE_NS, T_CLK_NS);
  localparam int DATA_CYC = max2(1, max2(SD_CYC, PWE_CYC - 1));
  localparam int CNT_W    = $clog2(max2(ACC_CYC, DATA_CYC) + 1);

  phase_e phase_d;
  logic   accept, capture, finish;

  sramc_seq #(
    .ACC_CYC (ACC_CYC),
    .DATA_CYC(DATA_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .phase_d  (phase_d),
    .accept   (accept),
    .capture  (capture),
    .finish   (finish)
  );

  sramc_pins u_pins (
    .clk    (clk),
    .rst    (rst),
    .phase_d(phase_d),
    .sel_n  (mem_sel_n),
    .sel    (mem_sel),
    .we_n   (mem_we_n),
    .oe_n   (mem_oe_n),
    .drv    (mem_dq_oe)
  );

  sramc_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .capture  (capture),
    .finish   (finish),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_i     (mem_dq_i),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_o),
    .rdata_q  (rsp_rdata),
    .done_q   (rsp_done)
  );

  // R7: address steady while the chip remains selected
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R1: idle pins whenever completion is signalled
  a_r1_idle_on_done: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int ACC_MIN  = 2;   // ceil(12/10)
  localparam int DATA_MIN = 1;   // max(ceil(7/10), ceil(10/10)-1, 1)
  localparam int WR_LAT   = 4 + DATA_MIN;
  localparam int RD_LAT   = ACC_MIN + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = '0;

  int checks = 0, errors = 0, commits = 0;

  sram_async_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
  endfunction

  // memory model storage and bench reference, kept separately
  logic [7:0] mem_m [int];
  logic [7:0] ref_m [int];

  function automatic logic [7:0] mem_rd(input logic [16:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : dflt(a);
  endfunction

  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : dflt(a);
  endfunction

  // Memory model and pin monitor, evaluated mid-cycle.
  logic        p_ov = 0, p_drv = 0, p_we_n = 1, p_oe_n = 1;
  logic [7:0]  p_dq = 0;
  logic [16:0] p_addr = 0;
  int          pulse_len = 0, drv_len = 0, rd_age = 0;

  always @(negedge clk) begin
    logic ov, rd;
    ov = !mem_sel_n && mem_sel && !mem_we_n;
    rd = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
    if (rst) begin
      p_ov = 0; p_drv = 0; p_we_n = 1; p_oe_n = 1; pulse_len = 0; drv_len = 0; rd_age = 0;
      mem_dq_i <= 8'h00;
    end else begin
      rd_age = rd ? rd_age + 1 : 0;
      mem_dq_i <= (rd && rd_age >= ACC_MIN) ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
      if (mem_dq_oe && !(mem_oe_n && !mem_sel_n && mem_sel))
        chk(0, "R6 drive while memory may drive", 1, 0);
      if (mem_dq_oe && !mem_we_n && p_we_n)
        chk(0, "R6 drive in first strobe cycle", 1, 0);
      if (mem_dq_oe && !p_oe_n)
        chk(0, "R6 drive right after read", 1, 0);
      if (!mem_we_n && !mem_oe_n)
        chk(0, "R4 oe and we both low", 1, 0);
      if (ov) begin
        if (mem_sel_n == 1'b0 && p_ov && mem_addr != p_addr)
          chk(0, "R7 address moved in write", int'(mem_addr), int'(p_addr));
        pulse_len++;
        drv_len = mem_dq_oe ? drv_len + 1 : 0;
      end
      if (p_ov && !ov) begin
        chk(pulse_len == DATA_MIN + 1, "R4 pulse length", pulse_len, DATA_MIN + 1);
        chk(drv_len >= DATA_MIN, "R3 setup cycles", drv_len, DATA_MIN);
        chk(mem_dq_oe && mem_dq_o == p_dq, "R3 hold", int'(mem_dq_o), int'(p_dq));
        mem_m[int'(p_addr)] = p_dq;
        commits++;
        pulse_len = 0;
        drv_len = 0;
      end
      p_ov = ov; p_drv = mem_dq_oe; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
      p_dq = mem_dq_o; p_addr = mem_addr;
    end
  end

  // One transaction; called at a negedge, returns at the negedge showing completion.
  task automatic txn(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit flood);
    int n = 0;
    bit got = 0;
    int c0 = commits;
    logic [7:0] rd_before = rsp_rdata;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (flood) begin
        req_addr = a ^ 17'h0155; req_wdata = ~d;
      end else begin
        req_valid = 0;
      end
      if (!mem_sel_n)
        chk(mem_addr == a, "R7 address while selected", int'(mem_addr), int'(a));
      if (wr && n < WR_LAT)
        chk(rsp_rdata == rd_before, "R10 rdata held during write", int'(rsp_rdata), int'(rd_before));
      if (rsp_done) got = 1;
    end
    req_valid = 0;
    chk(n == (wr ? WR_LAT : RD_LAT), "R8 completion latency", n, wr ? WR_LAT : RD_LAT);
    if (wr) begin
      ref_m[int'(a)] = d;
      chk(commits == c0 + 1, flood ? "R9 single commit" : "R2 single commit", commits - c0, 1);
      chk(rsp_rdata == rd_before, "R10 rdata after write", int'(rsp_rdata), int'(rd_before));
    end else begin
      chk(rsp_rdata == ref_rd(a), "R5 read data", int'(rsp_rdata), int'(ref_rd(a)));
      chk(commits == c0, "R9 no commit on read", commits - c0, 0);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done, tag,
        int'({mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}), 6'b101100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    idle_pins("R1 during reset");
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    idle_pins("R1 after reset");
    chk(rsp_rdata == 8'h00, "R1 rdata reset", int'(rsp_rdata), 0);

    // directed corners
    txn(0, 17'h00000, 8'h00, 0);                  // R5 default content
    txn(1, 17'h00000, 8'hFF, 0);                  // R2 lowest address
    txn(1, 17'h1FFFF, 8'h00, 0);                  // R2 highest address
    txn(0, 17'h00000, 8'h00, 0);                  // R5 read back, then write right after (R6)
    txn(1, 17'h00001, 8'hA5, 0);
    txn(0, 17'h1FFFF, 8'h00, 0);
    txn(0, 17'h00001, 8'h00, 0);
    @(negedge clk);
    idle_pins("R1 idle after transaction");
    chk(rsp_rdata == 8'hA5, "R10 rdata held in idle", int'(rsp_rdata), 8'hA5);
    // R9: keep request high with other fields during a write and a read
    txn(1, 17'h00200, 8'h3C, 1);
    txn(0, 17'h00200 ^ 17'h0155, 8'h00, 0);       // location the flood pointed at stays untouched
    txn(0, 17'h00200, 8'h00, 1);
    txn(0, 17'h00200, 8'h00, 0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      int pick = int'($urandom % 8);
      if (pick == 0)      a = 17'h00000;
      else if (pick == 1) a = 17'h1FFFF;
      else                a = 17'h00100 + 17'($urandom % 64);
      txn(1'($urandom % 2), a, 8'($urandom), 0);
      repeat ($urandom % 3) @(negedge clk);
    end

    @(negedge clk);
    idle_pins("R1 final idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule